// File: doc/BRIEF.md
# Misaligned Load/Store Access Splitter

This block sits between a core's load/store stage and a 32-bit data-side memory bus. It takes one byte, halfword or word access at any byte address. It turns that access into one or two word-aligned bus transactions. Each transaction carries an aligned address, per-lane byte enables and store data shifted onto the matching lanes. When an access crosses a word boundary, the block issues the lower word first and then the next word. It marks the two transactions as the low and high part of a misaligned access. An unaligned access that fits inside one word goes out as a single transaction, marked as the low part.

For loads, the block keeps the low part's returned word in a register until the high part's response arrives. It then selects the addressed bytes and extends them to the full width, with sign or zero extension as the request asks. The core sees exactly one completion per access, together with the load result and an error flag. If the low part of a split access returns an error, the high part is never issued.

Top module: `lsu_split`

## Requirements
- R1: Every bus transaction has the low two bits of `bus_addr_o` at zero. The low address bits of the request are expressed only through `bus_be_o`.
- R2: `bus_be_o` bit i is set exactly when byte (aligned address + i) belongs to the access. On a store, byte lane i of `bus_wdata_o` carries store-data byte (aligned address + i − request address). For example, a byte store of 0xFF to 0x12 issues address 0x10, data 0x00FF0000 and byte enables 0b0100.
- R3: An access whose bytes span two aligned words issues two transactions. The first goes to the lower word with `bus_first_o`=1. The second goes to the lower word + 4 with `bus_second_o`=1. Such accesses are a halfword at offset 3 and a word at offsets 1, 2 or 3.
- R4: An access that fits in one aligned word issues exactly one transaction. It has `bus_first_o`=1 if the address is not a multiple of the access size and 0 otherwise, and `bus_second_o`=0.
- R5: While `bus_req_o` is high and `bus_gnt_i` is low, the request and all bus outputs hold their values into the next cycle.
- R6: For loads, `rdata_o` holds the addressed bytes, read little-endian. A byte or halfword is sign-extended when `req_unsigned_i`=0 and zero-extended when it is 1. The size encoding of `req_size_i` is 0 for a byte, 1 for a halfword and 2 for a word.
- R7: If the first transaction of a split access returns `bus_err_i`, no second transaction is issued, and the access completes with `err_o`=1. An error on the last transaction also sets `err_o`.
- R8: `done_o` pulses for exactly one cycle per accepted access. It comes in the cycle after the final response. `req_ready_o` is high only while no access is in progress.
- R9: `bus_we_o` equals the store flag of the request on every transaction of the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Core access request |
| req_ready_o | output | 1 | Block idle; request accepted this cycle |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| req_unsigned_i | input | 1 | Zero-extend load result |
| req_addr_i | input | AW | Byte address |
| req_wdata_i | input | DW | Store data, right-aligned |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Completion had an error response |
| rdata_o | output | DW | Extended load result, valid with done_o |
| bus_req_o | output | 1 | Bus transaction request |
| bus_gnt_i | input | 1 | Bus grant |
| bus_addr_o | output | AW | Word-aligned address |
| bus_we_o | output | 1 | Write enable |
| bus_be_o | output | DW/8 | Byte enables |
| bus_wdata_o | output | DW | Lane-shifted store data |
| bus_first_o | output | 1 | Low part of a misaligned access |
| bus_second_o | output | 1 | High part of a misaligned access |
| bus_rvalid_i | input | 1 | Response valid |
| bus_rdata_i | input | DW | Response load data |
| bus_err_i | input | 1 | Response error |

## Verification
The bench targets the boundary offsets:
- A halfword at offset 3 and words at offsets 1 to 3 must split. A design that misjudges the crossing would send a truncated single word, or a spurious second transaction for a halfword at offset 1.
- Split loads with set top bits check the reassembly and the sign extension. Wrong byte order or a lost held low word shows up as a wrong `rdata_o`.
- Error injection on the first half checks that the high transaction is suppressed, and that one completion still arrives with the error set.
- Grant delays check that the bus outputs hold steady while the request waits.

// File: rtl/lsu_split_pkg.sv
package lsu_split_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_REQ_LO  = 3'd1,
      ST_WAIT_LO = 3'd2,
      ST_REQ_HI  = 3'd3,
      ST_WAIT_HI = 3'd4
   } seq_state_e;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;

   function automatic int unsigned size_bytes(input logic [1:0] sz);
      case (sz)
         SZ_BYTE: return 1;
         SZ_HALF: return 2;
         default: return 4;
      endcase
   endfunction

endpackage

// File: rtl/lsu_split_lanes.sv
module lsu_split_lanes #(
   parameter int DW = 32,
   localparam int NB = DW / 8,
   localparam int OFFW = $clog2(NB)
) (
   input  logic [OFFW-1:0] off_i,
   input  logic [1:0]      size_i,
   input  logic [DW-1:0]   wdata_i,
   output logic [NB-1:0]   be_lo_o,
   output logic [NB-1:0]   be_hi_o,
   output logic [DW-1:0]   wd_lo_o,
   output logic [DW-1:0]   wd_hi_o,
   output logic            crosses_o,
   output logic            misal_o
);
   import lsu_split_pkg::*;

   logic [2*NB-1:0] mask_base, mask_sh;
   logic [DW-1:0]   wclean;
   logic [2*DW-1:0] wd_sh;
   logic [OFFW-1:0] amask;

   // Clear store bytes above the access size, one lane per generate branch.
   for (genvar b = 0; b < NB; b++) begin : g_clean
      assign wclean[b*8 +: 8] = (b < int'(size_bytes(size_i))) ? wdata_i[b*8 +: 8] : 8'h00;
   end

   always_comb begin
      case (size_i)
         SZ_BYTE: begin mask_base = (2*NB)'(1);  amask = '0;          end
         SZ_HALF: begin mask_base = (2*NB)'(3);  amask = OFFW'(1);    end
         default: begin mask_base = (2*NB)'(15); amask = OFFW'(3);    end
      endcase
      mask_sh   = mask_base << off_i;
      wd_sh     = {{DW{1'b0}}, wclean} << {off_i, 3'b000};
      be_lo_o   = mask_sh[NB-1:0];
      be_hi_o   = mask_sh[2*NB-1:NB];
      wd_lo_o   = wd_sh[DW-1:0];
      wd_hi_o   = wd_sh[2*DW-1:DW];
      crosses_o = |mask_sh[2*NB-1:NB];
      misal_o   = |(off_i & amask);
   end

endmodule

// File: rtl/lsu_split_merge.sv
module lsu_split_merge #(
   parameter int DW = 32,
   localparam int NB = DW / 8,
   localparam int OFFW = $clog2(NB)
) (
   input  logic [OFFW-1:0] off_i,
   input  logic [1:0]      size_i,
   input  logic            uns_i,
   input  logic [DW-1:0]   lo_word_i,
   input  logic [DW-1:0]   hi_word_i,
   output logic [DW-1:0]   result_o
);
   import lsu_split_pkg::*;

   logic [2*DW-1:0] cat_sh;
   logic [DW-1:0]   raw;
   logic            sgn;

   always_comb begin
      cat_sh = {hi_word_i, lo_word_i} >> {off_i, 3'b000};
      raw    = cat_sh[DW-1:0];
      case (size_i)
         SZ_BYTE: begin
            sgn      = raw[7] & ~uns_i;
            result_o = {{(DW-8){sgn}}, raw[7:0]};
         end
         SZ_HALF: begin
            sgn      = raw[15] & ~uns_i;
            result_o = {{(DW-16){sgn}}, raw[15:0]};
         end
         default: begin
            sgn      = raw[31] & ~uns_i;
            result_o = (DW > 32) ? {{(DW-32){sgn}}, raw[31:0]} : raw;
         end
      endcase
   end

endmodule

// File: rtl/lsu_split_seq.sv
module lsu_split_seq (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic crosses_i,
   input  logic gnt_i,
   input  logic rvalid_i,
   input  logic err_i,
   output logic idle_o,
   output logic bus_req_o,
   output logic hi_phase_o,
   output logic finish_o,
   output logic take_lo_o
);
   import lsu_split_pkg::*;

   seq_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:    if (start_i) st_d = ST_REQ_LO;
         ST_REQ_LO:  if (gnt_i)   st_d = ST_WAIT_LO;
         ST_WAIT_LO: if (rvalid_i) st_d = (crosses_i && !err_i) ? ST_REQ_HI : ST_IDLE;
         ST_REQ_HI:  if (gnt_i)   st_d = ST_WAIT_HI;
         ST_WAIT_HI: if (rvalid_i) st_d = ST_IDLE;
         default:    st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= ST_IDLE;
      else         st_q <= st_d;
   end

   assign idle_o     = (st_q == ST_IDLE);
   assign bus_req_o  = (st_q == ST_REQ_LO) || (st_q == ST_REQ_HI);
   assign hi_phase_o = (st_q == ST_REQ_HI) || (st_q == ST_WAIT_HI);
   assign take_lo_o  = rvalid_i && (st_q == ST_WAIT_LO) && crosses_i && !err_i;
   assign finish_o   = rvalid_i && (((st_q == ST_WAIT_LO) && (err_i || !crosses_i))
                                    || (st_q == ST_WAIT_HI));

endmodule

// File: rtl/lsu_split.sv
module lsu_split #(
   parameter int AW = 32,
   parameter int DW = 32,
   localparam int NB = DW / 8,
   localparam int OFFW = $clog2(NB)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          req_valid_i,
   output logic          req_ready_o,
   input  logic          req_store_i,
   input  logic [1:0]    req_size_i,
   input  logic          req_unsigned_i,
   input  logic [AW-1:0] req_addr_i,
   input  logic [DW-1:0] req_wdata_i,
   output logic          done_o,
   output logic          err_o,
   output logic [DW-1:0] rdata_o,
   output logic          bus_req_o,
   input  logic          bus_gnt_i,
   output logic [AW-1:0] bus_addr_o,
   output logic          bus_we_o,
   output logic [NB-1:0] bus_be_o,
   output logic [DW-1:0] bus_wdata_o,
   output logic          bus_first_o,
   output logic          bus_second_o,
   input  logic          bus_rvalid_i,
   input  logic [DW-1:0] bus_rdata_i,
   input  logic          bus_err_i
);

   if (DW < 32 || (DW & (DW - 1)) != 0) begin : g_bad_dw
      $error("lsu_split: DW must be a power of two of at least 32");
   end
   if (AW <= OFFW) begin : g_bad_aw
      $error("lsu_split: AW must exceed the byte-offset width");
   end

   logic          q_store, q_uns;
   logic [1:0]    q_size;
   logic [AW-1:0] q_addr;
   logic [DW-1:0] q_wdata, lo_q, merged;
   logic          done_q, err_q;
   logic [DW-1:0] rdata_q;

   logic          idle, start, hi_phase, finish, take_lo, crosses, misal;
   logic [NB-1:0] be_lo, be_hi;
   logic [DW-1:0] wd_lo, wd_hi;

   assign start = req_valid_i && idle;

   lsu_split_seq i_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start),
      .crosses_i  (crosses),
      .gnt_i      (bus_gnt_i),
      .rvalid_i   (bus_rvalid_i),
      .err_i      (bus_err_i),
      .idle_o     (idle),
      .bus_req_o  (bus_req_o),
      .hi_phase_o (hi_phase),
      .finish_o   (finish),
      .take_lo_o  (take_lo)
   );

   lsu_split_lanes #(.DW(DW)) i_lanes (
      .off_i     (q_addr[OFFW-1:0]),
      .size_i    (q_size),
      .wdata_i   (q_wdata),
      .be_lo_o   (be_lo),
      .be_hi_o   (be_hi),
      .wd_lo_o   (wd_lo),
      .wd_hi_o   (wd_hi),
      .crosses_o (crosses),
      .misal_o   (misal)
   );

   lsu_split_merge #(.DW(DW)) i_merge (
      .off_i     (q_addr[OFFW-1:0]),
      .size_i    (q_size),
      .uns_i     (q_uns),
      .lo_word_i (hi_phase ? lo_q : bus_rdata_i),
      .hi_word_i (hi_phase ? bus_rdata_i : '0),
      .result_o  (merged)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         q_store <= 1'b0;
         q_uns   <= 1'b0;
         q_size  <= '0;
         q_addr  <= '0;
         q_wdata <= '0;
         lo_q    <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         done_q <= finish;
         if (start) begin
            q_store <= req_store_i;
            q_uns   <= req_unsigned_i;
            q_size  <= req_size_i;
            q_addr  <= req_addr_i;
            q_wdata <= req_wdata_i;
         end
         if (take_lo) lo_q <= bus_rdata_i;
         if (finish) begin
            err_q   <= bus_err_i;
            rdata_q <= q_store ? '0 : merged;
         end
      end
   end

   assign req_ready_o  = idle;
   assign done_o       = done_q;
   assign err_o        = err_q;
   assign rdata_o      = rdata_q;
   assign bus_addr_o   = {q_addr[AW-1:OFFW] + (AW-OFFW)'(hi_phase), {OFFW{1'b0}}};
   assign bus_we_o     = q_store;
   assign bus_be_o     = hi_phase ? be_hi : be_lo;
   assign bus_wdata_o  = hi_phase ? wd_hi : wd_lo;
   assign bus_first_o  = misal && !hi_phase;
   assign bus_second_o = hi_phase;

endmodule

// File: rtl/lsu_split_chk.sv
module lsu_split_chk #(
   parameter int AW = 32,
   parameter int DW = 32,
   localparam int NB = DW / 8,
   localparam int OFFW = $clog2(NB)
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          req_ready_o,
   input logic          done_o,
   input logic          bus_req_o,
   input logic          bus_gnt_i,
   input logic [AW-1:0] bus_addr_o,
   input logic          bus_we_o,
   input logic [NB-1:0] bus_be_o,
   input logic [DW-1:0] bus_wdata_o,
   input logic          bus_first_o,
   input logic          bus_second_o
);

   p_addr_aligned_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_req_o |-> (bus_addr_o[OFFW-1:0] == '0));

   p_be_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_req_o |-> (bus_be_o != '0));

   p_part_flags_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_req_o |-> !(bus_first_o && bus_second_o));

   p_hold_until_gnt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_req_o && !bus_gnt_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_be_o)
                                     && $stable(bus_wdata_o) && $stable(bus_we_o)));

   p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   p_busy_not_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_req_o |-> !req_ready_o);

endmodule

bind lsu_split lsu_split_chk #(.AW(AW), .DW(DW)) i_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .req_ready_o  (req_ready_o),
   .done_o       (done_o),
   .bus_req_o    (bus_req_o),
   .bus_gnt_i    (bus_gnt_i),
   .bus_addr_o   (bus_addr_o),
   .bus_we_o     (bus_we_o),
   .bus_be_o     (bus_be_o),
   .bus_wdata_o  (bus_wdata_o),
   .bus_first_o  (bus_first_o),
   .bus_second_o (bus_second_o)
);

// File: tb/test_lsu_split.sv
module test_lsu_split;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_store = 1'b0, req_uns = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic        bus_gnt = 1'b0, bus_rvalid = 1'b0, bus_err = 1'b0;
   logic [31:0] bus_rdata = '0;

   logic        req_ready, done, err, bus_req, bus_we, bus_first, bus_second;
   logic [31:0] rdata, bus_addr, bus_wdata;
   logic [3:0]  bus_be;

   int checks = 0;
   int fails = 0;

   logic [7:0] bmem [64];
   logic [7:0] rmem [64];

   always #2.5 clk = ~clk;

   lsu_split #(.AW(32), .DW(32)) i_lsu_split (
      .clk_i(clk), .rst_ni(rst_n),
      .req_valid_i(req_valid), .req_ready_o(req_ready), .req_store_i(req_store),
      .req_size_i(req_size), .req_unsigned_i(req_uns), .req_addr_i(req_addr),
      .req_wdata_i(req_wdata), .done_o(done), .err_o(err), .rdata_o(rdata),
      .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_addr_o(bus_addr),
      .bus_we_o(bus_we), .bus_be_o(bus_be), .bus_wdata_o(bus_wdata),
      .bus_first_o(bus_first), .bus_second_o(bus_second),
      .bus_rvalid_i(bus_rvalid), .bus_rdata_i(bus_rdata), .bus_err_i(bus_err)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_be(input int addr, input int n, input int base);
      logic [3:0] r;
      for (int i = 0; i < 4; i++) r[i] = (base + i >= addr) && (base + i < addr + n);
      return r;
   endfunction

   function automatic logic [31:0] exp_load(input int addr, input int sz, input bit uns);
      int n = 1 << sz;
      logic [31:0] v = '0;
      for (int j = 0; j < n; j++) v[8*j +: 8] = rmem[addr + j];
      if (!uns && sz == 0) v = {{24{v[7]}}, v[7:0]};
      if (!uns && sz == 1) v = {{16{v[15]}}, v[15:0]};
      return v;
   endfunction

   task automatic do_access(input bit st, input int sz, input bit uns, input int addr,
                            input logic [31:0] wd, input bit e_lo, input bit e_hi, input int dly);
      int n = 1 << sz;
      int off = addr % 4;
      int exp_ntx = (off + n > 4) ? 2 : 1;
      bit exp_mis = (addr % n) != 0;
      int ntx = 0;
      bit got_done = 0;
      bit got_err = 0;
      logic [31:0] got_data = '0;
      bit exp_err;
      @(negedge clk);
      chk(req_ready == 1'b1, "R8 ready when idle", {31'd0, req_ready}, 32'd1);
      req_valid = 1'b1; req_store = st; req_size = 2'(sz); req_uns = uns;
      req_addr = addr; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0; req_wdata = $urandom;
      for (int ph = 0; ph < 2 && !got_done; ph++) begin
         int base = (addr & ~3) + 4 * ph;
         logic [31:0] s_addr, s_wd;
         logic [3:0]  s_be, ebe;
         logic [31:0] ewd = '0;
         bit e_now;
         for (int w = 0; w < 6 && !bus_req; w++) @(negedge clk);
         chk(bus_req == 1'b1, "R3 transaction issued", {31'd0, bus_req}, 32'd1);
         s_addr = bus_addr; s_be = bus_be; s_wd = bus_wdata;
         ebe = exp_be(addr, n, base);
         chk(bus_addr == 32'(base), "R1/R3 aligned address", bus_addr, 32'(base));
         chk(bus_we == st, "R9 write flag", {31'd0, bus_we}, {31'd0, st});
         chk(bus_first == (ph == 0 && exp_mis), "R4/R3 first-part flag", {31'd0, bus_first},
             {31'd0, (ph == 0 && exp_mis)});
         chk(bus_second == (ph == 1), "R3 second-part flag", {31'd0, bus_second}, 32'(ph));
         chk(bus_be == ebe, "R2 byte enables", {28'd0, bus_be}, {28'd0, ebe});
         if (st) begin
            logic [31:0] msk = '0;
            for (int i = 0; i < 4; i++)
               if (ebe[i]) begin
                  ewd[8*i +: 8] = wd[8*(base + i - addr) +: 8];
                  msk[8*i +: 8] = 8'hFF;
               end
            chk((bus_wdata & msk) == ewd, "R2 store lanes", bus_wdata & msk, ewd);
         end
         for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            chk(bus_req && bus_addr == s_addr && bus_be == s_be && bus_wdata == s_wd,
                "R5 hold while waiting", bus_addr, s_addr);
         end
         bus_gnt = 1'b1;
         @(negedge clk);
         bus_gnt = 1'b0;
         ntx++;
         e_now = (ph == 0) ? e_lo : e_hi;
         for (int i = 0; i < 4; i++) bus_rdata[8*i +: 8] = bmem[(base + i) % 64];
         bus_rvalid = 1'b1; bus_err = e_now;
         if (st && !e_now)
            for (int i = 0; i < 4; i++) if (bus_be[i]) bmem[(base + i) % 64] = bus_wdata[8*i +: 8];
         @(negedge clk);
         bus_rvalid = 1'b0; bus_err = 1'b0; bus_rdata = $urandom;
         if (done) begin
            got_done = 1; got_err = err; got_data = rdata;
         end
      end
      exp_err = e_lo || (exp_ntx == 2 && e_hi);
      chk(ntx == (e_lo ? 1 : exp_ntx), "R3/R4/R7 transaction count", 32'(ntx),
          32'(e_lo ? 1 : exp_ntx));
      chk(got_done, "R8 completion after final response", {31'd0, got_done}, 32'd1);
      chk(got_err == exp_err, "R7 error report", {31'd0, got_err}, {31'd0, exp_err});
      if (!st && !exp_err)
         chk(got_data == exp_load(addr, sz, uns), "R6 load result", got_data, exp_load(addr, sz, uns));
      @(negedge clk);
      chk(done == 1'b0 && bus_req == 1'b0, "R8 single pulse, no extra transaction",
          {30'd0, done, bus_req}, 32'd0);
      if (st && !exp_err) begin
         for (int j = 0; j < n; j++) rmem[addr + j] = wd[8*j +: 8];
         for (int j = 0; j < 64; j++)
            chk(bmem[j] == rmem[j], "R2 memory image after store", {24'd0, bmem[j]}, {24'd0, rmem[j]});
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd77));
      for (int j = 0; j < 64; j++) begin
         bmem[j] = 8'($urandom);
         rmem[j] = bmem[j];
      end
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1 && bus_req == 1'b0 && done == 1'b0, "R8 reset state",
          {29'd0, req_ready, bus_req, done}, 32'd4);
      rst_n = 1'b1;
      @(negedge clk);

      do_access(1, 0, 0, 32'h12, 32'h000000FF, 0, 0, 0);   // R2 directed example
      chk(bmem[8'h12] == 8'hFF, "R2 byte store landed", {24'd0, bmem[8'h12]}, 32'hFF);
      for (int j = 0; j < 8; j++) begin bmem[j] = 8'h80 + 8'(j); rmem[j] = bmem[j]; end
      do_access(0, 2, 0, 3, '0, 0, 0, 1);                   // R3 word at offset 3
      do_access(0, 1, 0, 1, '0, 0, 0, 0);                   // R4 half at offset 1
      do_access(0, 1, 0, 3, '0, 0, 0, 2);                   // R3 half at offset 3, signed
      do_access(0, 1, 1, 3, '0, 0, 0, 0);                   // R6 unsigned
      do_access(0, 0, 0, 5, '0, 0, 0, 0);                   // R6 signed byte
      do_access(0, 2, 0, 4, '0, 0, 0, 0);                   // R4 aligned word
      do_access(1, 2, 0, 6, 32'hA1B2C3D4, 0, 0, 1);         // R3 split store
      do_access(0, 2, 0, 2, '0, 1, 0, 0);                   // R7 first-half error
      do_access(0, 2, 0, 1, '0, 0, 1, 0);                   // R7 second-half error
      do_access(0, 0, 0, 8, '0, 1, 0, 0);                   // R7 single error

      for (int it = 0; it < 400; it++) begin
         bit st = 1'($urandom);
         int sz = $urandom % 3;
         int ad = $urandom % 60;
         bit el = !st && ($urandom % 8 == 0);
         bit eh = !st && ($urandom % 8 == 0);
         do_access(st, sz, 1'($urandom), ad, $urandom, el, eh, $urandom % 3);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule